// File: doc/BRIEF.md
# Banked Block-Copy DMA Engine

This block is a byte-wide, register-programmed copy engine that moves blocks of bytes between a core memory port and a peripheral memory port. The peripheral side is reached through a window of two halves. Each half has its own bank-select register, so the physical peripheral address of a byte is the selected bank joined to the byte's offset inside the half. Software fills in a lane descriptor: core address, peripheral address, byte count, and a starting and ending bank. It then writes a command byte to that lane's control register to start a copy in either direction.

A descriptor's peripheral address may run past the end of a half. When it does, the engine steps the active bank one value toward the ending bank at every half boundary. It writes the stepped value into the bank-select register of the half being entered. When the copy finishes, both bank-select registers get back the values they held just before it started. Lanes are served one at a time. Whenever the engine is free it takes the lowest-numbered lane with a command pending. Each cycle in which both memory ports grant access moves one byte.

Top module: `bank_dma`

## Requirements
- R1: Register offsets 0 and 1 hold the bank selects for the lower and upper half of the peripheral window. They read back what was written and reset to 0.
- R2: Lane n (1-based) occupies 11 bytes starting at offset 32 + 11*(n-1), laid out as follows, with every multi-byte field least significant byte first:
  - bytes 0-2: core address
  - bytes 3-5: peripheral address
  - bytes 6-8: byte count
  - byte 9: first bank
  - byte 10: last bank
  - All bytes read back what was written.
- R3: Writing 0x01 to lane n's control register (offset 15+n) copies the byte at core address ca+i to peripheral byte i, for i from 0 to count-1. Writing 0x02 copies peripheral byte i to core address ca+i.
- R4: A control register reads back the command value while its lane is pending or copying, and reads 0 once the copy is done. Any other command value, and any command written while the lane is already busy, is ignored.
- R5: A byte count of 0 completes without any request on either memory port.
- R6: Peripheral byte i lives at offset (p + i) mod H inside a half, where p is the peripheral address modulo the half size H. Its bank is the first bank stepped once toward the last bank for each half boundary crossed before it. The bank moves up or down as needed and stops at the last bank. Bit log2(H) of the running peripheral address picks which bank-select register carries that bank, and the physical peripheral address is {bank, offset}.
- R7: One cycle after a copy completes, both bank-select registers hold the values they had when the copy started.
- R8: Only one lane copies at a time. When several lanes are pending, the lowest-numbered one is served first.
- R9: Each cycle in which both port grants are high moves exactly one byte. A cycle in which either grant is low moves nothing, and the requests stay asserted.
- R10: While a lane is copying, writes to that lane's descriptor bytes and writes to offsets 0 and 1 are ignored.
- R11: Offsets 24 to 31 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | REG_AW | Register write offset |
| reg_wdata | input | 8 | Register write byte |
| reg_raddr | input | REG_AW | Register read offset |
| reg_rdata | output | 8 | Register read byte (combinational) |
| core_req | output | 1 | Core port access request |
| core_we | output | 1 | Core port write (1) or read (0) |
| core_addr | output | CORE_AW | Core byte address |
| core_wdata | output | 8 | Byte written to core memory |
| core_rdata | input | 8 | Byte read from core memory, valid with grant |
| core_gnt | input | 1 | Core port grant |
| per_req | output | 1 | Peripheral port access request |
| per_we | output | 1 | Peripheral port write (1) or read (0) |
| per_addr | output | BANK_W+HALF_W | Physical peripheral address {bank, offset} |
| per_wdata | output | 8 | Byte written to the peripheral |
| per_rdata | input | 8 | Byte read from the peripheral, valid with grant |
| per_gnt | input | 1 | Peripheral port grant |

## Verification
The bench builds the engine with HALF_W=4, BANK_W=4 and CORE_AW=8. Each window half is then 16 bytes, and both memories are 256-byte arrays that the bench models in full. With these sizes a copy of a few dozen bytes crosses several half boundaries. Upward stepping, downward stepping and the stop at the last bank can therefore each be observed in a short run, together with the restore of the bank selects. All eight lanes are kept, so the descriptor stride reaches the last lane and the ascending service order can be shown across non-adjacent lanes.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

  localparam int CTRL_BASE   = 16;
  localparam int CTRL_END    = 32;
  localparam int LANE_BASE   = 32;
  localparam int LANE_STRIDE = 11;
  localparam int FLD_BYTES   = 3;

  localparam logic [7:0] CMD_TO_PER  = 8'h01;
  localparam logic [7:0] CMD_TO_CORE = 8'h02;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_RUN  = 2'd1,
    MV_FIN  = 2'd2
  } mv_state_e;

  typedef struct packed {
    logic [8*FLD_BYTES-1:0] core_addr;
    logic [8*FLD_BYTES-1:0] per_addr;
    logic [8*FLD_BYTES-1:0] length;
    logic [7:0]             first_bank;
    logic [7:0]             last_bank;
    logic                   to_core;
  } lane_desc_t;

  function automatic logic is_cmd(input logic [7:0] v);
    return (v == CMD_TO_PER) || (v == CMD_TO_CORE);
  endfunction

  function automatic logic [7:0] bank_step(input logic [7:0] cur, input logic [7:0] last);
    if (cur < last)      return cur + 8'd1;
    else if (cur > last) return cur - 8'd1;
    else                 return cur;
  endfunction

  function automatic int lane_byte_off(input int lane, input int k);
    return LANE_BASE + lane * LANE_STRIDE + k;
  endfunction

endpackage

// File: rtl/bdma_lane_regs.sv
module bdma_lane_regs
  import bdma_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int REG_AW    = 8,
  parameter int LANE_IW   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [REG_AW-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic [REG_AW-1:0]  rd_addr_i,
  output logic [7:0]         rd_data_o,
  input  logic [NUM_LANES-1:0] lock_i,
  input  logic               done_i,
  input  logic [LANE_IW-1:0] done_lane_i,
  output logic [NUM_LANES-1:0] pending_o,
  output lane_desc_t         desc_o [NUM_LANES]
);

  logic [7:0] fld_q [NUM_LANES][LANE_STRIDE];
  logic [7:0] cmd_q [NUM_LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        cmd_q[l] <= '0;
        for (int k = 0; k < LANE_STRIDE; k++) fld_q[l][k] <= '0;
      end
    end else begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if (done_i && done_lane_i == LANE_IW'(l))
          cmd_q[l] <= '0;
        else if (wr_en_i && int'(wr_addr_i) == CTRL_BASE + l &&
                 cmd_q[l] == '0 && is_cmd(wr_data_i))
          cmd_q[l] <= wr_data_i;
        for (int k = 0; k < LANE_STRIDE; k++)
          if (wr_en_i && !lock_i[l] && int'(wr_addr_i) == lane_byte_off(l, k))
            fld_q[l][k] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (int'(rd_addr_i) == CTRL_BASE + l) rd_data_o = cmd_q[l];
      for (int k = 0; k < LANE_STRIDE; k++)
        if (int'(rd_addr_i) == lane_byte_off(l, k)) rd_data_o = fld_q[l][k];
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LO = LANE_BASE + g * LANE_STRIDE;
    logic ctrl_bad_wr, fld_wr;

    assign pending_o[g] = (cmd_q[g] != '0);
    assign desc_o[g] = {fld_q[g][2], fld_q[g][1], fld_q[g][0],
                        fld_q[g][5], fld_q[g][4], fld_q[g][3],
                        fld_q[g][8], fld_q[g][7], fld_q[g][6],
                        fld_q[g][9], fld_q[g][10],
                        (cmd_q[g] == CMD_TO_CORE)};

    assign ctrl_bad_wr = wr_en_i && int'(wr_addr_i) == CTRL_BASE + g && !is_cmd(wr_data_i);
    assign fld_wr = wr_en_i && int'(wr_addr_i) >= LO && int'(wr_addr_i) < LO + LANE_STRIDE;

    AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_bad_wr && !pending_o[g] |=> !pending_o[g]); // R4
    AST_LOCKED_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fld_wr && lock_i[g] |=> $stable(desc_o[g])); // R10
  end

endmodule

// File: rtl/bdma_pick.sv
module bdma_pick #(
  parameter int NUM_LANES = 8,
  parameter int LANE_IW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] pending_i,
  output logic                 any_o,
  output logic [LANE_IW-1:0]   idx_o
);

  logic [NUM_LANES-1:0] grant_oh;

  always_comb begin
    idx_o    = '0;
    grant_oh = '0;
    for (int l = NUM_LANES - 1; l >= 0; l--) begin
      if (pending_i[l]) begin
        idx_o    = LANE_IW'(l);
        grant_oh = '0;
        grant_oh[l] = 1'b1;
      end
    end
  end

  assign any_o = |pending_i;

  AST_PICK_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (pending_i & grant_oh) != '0); // R8
  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (pending_i & (grant_oh - 1'b1)) == '0); // R8

endmodule

// File: rtl/bdma_mover.sv
module bdma_mover
  import bdma_pkg::*;
#(
  parameter int CORE_AW = 24,
  parameter int BANK_W  = 8,
  parameter int HALF_W  = 19,
  parameter int LANE_IW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [LANE_IW-1:0] start_lane_i,
  input  lane_desc_t         desc_i,
  input  logic               bank_wr_i,
  input  logic               bank_wsel_i,
  input  logic [7:0]         bank_wdata_i,
  output logic [7:0]         bank_lo_o,
  output logic [7:0]         bank_hi_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [LANE_IW-1:0] lane_o,
  output logic               core_req_o,
  output logic               core_we_o,
  output logic [CORE_AW-1:0] core_addr_o,
  output logic [7:0]         core_wdata_o,
  input  logic [7:0]         core_rdata_i,
  input  logic               core_gnt_i,
  output logic               per_req_o,
  output logic               per_we_o,
  output logic [BANK_W+HALF_W-1:0] per_addr_o,
  output logic [7:0]         per_wdata_o,
  input  logic [7:0]         per_rdata_i,
  input  logic               per_gnt_i
);

  localparam int PW = HALF_W + 1;

  mv_state_e            state_q;
  logic [CORE_AW-1:0]   caddr_q;
  logic [PW-1:0]        paddr_q;
  logic [8*FLD_BYTES-1:0] remain_q;
  logic [7:0]           bank_cur_q, bank_last_q;
  logic [7:0]           bank_lo_q, bank_hi_q, save_lo_q, save_hi_q;
  logic                 to_core_q;
  logic [LANE_IW-1:0]   lane_q;

  // Named events for the checks below
  logic       beat, crossing, half;
  logic [7:0] lo_in, hi_in, step_val, window_bank;

  assign beat        = (state_q == MV_RUN) && core_gnt_i && per_gnt_i;
  assign crossing    = beat && (&paddr_q[HALF_W-1:0]);
  assign half        = paddr_q[HALF_W];
  assign step_val    = bank_step(bank_cur_q, bank_last_q);
  assign window_bank = half ? bank_hi_q : bank_lo_q;
  assign lo_in       = (bank_wr_i && !bank_wsel_i) ? bank_wdata_i : bank_lo_q;
  assign hi_in       = (bank_wr_i &&  bank_wsel_i) ? bank_wdata_i : bank_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= MV_IDLE;
      caddr_q     <= '0;
      paddr_q     <= '0;
      remain_q    <= '0;
      bank_cur_q  <= '0;
      bank_last_q <= '0;
      bank_lo_q   <= '0;
      bank_hi_q   <= '0;
      save_lo_q   <= '0;
      save_hi_q   <= '0;
      to_core_q   <= 1'b0;
      lane_q      <= '0;
    end else begin
      unique case (state_q)
        MV_IDLE: begin
          bank_lo_q <= lo_in;
          bank_hi_q <= hi_in;
          if (start_i) begin
            save_lo_q   <= lo_in;
            save_hi_q   <= hi_in;
            lane_q      <= start_lane_i;
            caddr_q     <= desc_i.core_addr[CORE_AW-1:0];
            paddr_q     <= desc_i.per_addr[PW-1:0];
            remain_q    <= desc_i.length;
            bank_cur_q  <= desc_i.first_bank;
            bank_last_q <= desc_i.last_bank;
            to_core_q   <= desc_i.to_core;
            if (desc_i.length == '0) begin
              state_q <= MV_FIN;
            end else begin
              state_q <= MV_RUN;
              if (desc_i.per_addr[HALF_W]) bank_hi_q <= desc_i.first_bank;
              else                         bank_lo_q <= desc_i.first_bank;
            end
          end
        end
        MV_RUN: begin
          if (beat) begin
            caddr_q  <= caddr_q + 1'b1;
            paddr_q  <= paddr_q + 1'b1;
            remain_q <= remain_q - 1'b1;
            if (crossing) begin
              bank_cur_q <= step_val;
              if (half) bank_lo_q <= step_val;
              else      bank_hi_q <= step_val;
            end
            if (remain_q == 1) state_q <= MV_FIN;
          end
        end
        MV_FIN: begin
          bank_lo_q <= save_lo_q;
          bank_hi_q <= save_hi_q;
          state_q   <= MV_IDLE;
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != MV_IDLE);
  assign done_o       = (state_q == MV_FIN);
  assign lane_o       = lane_q;
  assign bank_lo_o    = bank_lo_q;
  assign bank_hi_o    = bank_hi_q;

  assign core_req_o   = (state_q == MV_RUN);
  assign core_we_o    = to_core_q;
  assign core_addr_o  = caddr_q;
  assign core_wdata_o = per_rdata_i;

  assign per_req_o    = (state_q == MV_RUN);
  assign per_we_o     = !to_core_q;
  assign per_addr_o   = {window_bank[BANK_W-1:0], paddr_q[HALF_W-1:0]};
  assign per_wdata_o  = core_rdata_i;

  logic unused_bits;
  assign unused_bits = ^{desc_i.core_addr, desc_i.per_addr, window_bank};

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_o |-> (core_we_o != per_we_o)); // R3
  AST_ZERO_LEN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && desc_i.length == '0 |=> !core_req_o && !per_req_o); // R5
  AST_WINDOW_TRACKS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == MV_RUN |-> window_bank == bank_cur_q); // R6
  AST_CROSS_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    crossing && bank_cur_q != bank_last_q |=> bank_cur_q != $past(bank_cur_q)); // R6
  AST_BANKS_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == MV_FIN |=> bank_lo_q == save_lo_q && bank_hi_q == save_hi_q); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == MV_RUN && !beat |=> $stable(remain_q) && core_req_o); // R9
  AST_BEAT_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    beat && remain_q > 1 |=> remain_q == $past(remain_q) - 1'b1); // R9
  AST_WINDOW_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == MV_RUN && !crossing |=> $stable(bank_lo_q) && $stable(bank_hi_q)); // R10

endmodule

// File: rtl/bank_dma.sv
module bank_dma
  import bdma_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int REG_AW    = 8,
  parameter int CORE_AW   = 24,
  parameter int BANK_W    = 8,
  parameter int HALF_W    = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [REG_AW-1:0]        reg_waddr,
  input  logic [7:0]               reg_wdata,
  input  logic [REG_AW-1:0]        reg_raddr,
  output logic [7:0]               reg_rdata,
  output logic                     core_req,
  output logic                     core_we,
  output logic [CORE_AW-1:0]       core_addr,
  output logic [7:0]               core_wdata,
  input  logic [7:0]               core_rdata,
  input  logic                     core_gnt,
  output logic                     per_req,
  output logic                     per_we,
  output logic [BANK_W+HALF_W-1:0] per_addr,
  output logic [7:0]               per_wdata,
  input  logic [7:0]               per_rdata,
  input  logic                     per_gnt
);

  localparam int LANE_IW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [NUM_LANES-1:0] pending, lock_oh;
  lane_desc_t           lane_desc [NUM_LANES];
  logic                 pick_any, start, busy, done;
  logic [LANE_IW-1:0]   pick_idx, run_lane;
  logic [7:0]           bank_lo, bank_hi, lane_rdata;
  logic                 bank_wr;

  assign bank_wr = reg_wr && (int'(reg_waddr) < 2);
  assign start   = pick_any && !busy;

  always_comb begin
    lock_oh = '0;
    if (busy) lock_oh[run_lane] = 1'b1;
  end

  bdma_lane_regs #(.NUM_LANES(NUM_LANES), .REG_AW(REG_AW), .LANE_IW(LANE_IW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(reg_wr), .wr_addr_i(reg_waddr), .wr_data_i(reg_wdata),
    .rd_addr_i(reg_raddr), .rd_data_o(lane_rdata),
    .lock_i(lock_oh), .done_i(done), .done_lane_i(run_lane),
    .pending_o(pending), .desc_o(lane_desc)
  );

  bdma_pick #(.NUM_LANES(NUM_LANES), .LANE_IW(LANE_IW)) u_pick (
    .clk(clk), .rst_n(rst_n), .pending_i(pending), .any_o(pick_any), .idx_o(pick_idx)
  );

  bdma_mover #(.CORE_AW(CORE_AW), .BANK_W(BANK_W), .HALF_W(HALF_W), .LANE_IW(LANE_IW)) u_mover (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .start_lane_i(pick_idx), .desc_i(lane_desc[pick_idx]),
    .bank_wr_i(bank_wr), .bank_wsel_i(reg_waddr[0]), .bank_wdata_i(reg_wdata),
    .bank_lo_o(bank_lo), .bank_hi_o(bank_hi),
    .busy_o(busy), .done_o(done), .lane_o(run_lane),
    .core_req_o(core_req), .core_we_o(core_we), .core_addr_o(core_addr),
    .core_wdata_o(core_wdata), .core_rdata_i(core_rdata), .core_gnt_i(core_gnt),
    .per_req_o(per_req), .per_we_o(per_we), .per_addr_o(per_addr),
    .per_wdata_o(per_wdata), .per_rdata_i(per_rdata), .per_gnt_i(per_gnt)
  );

  always_comb begin
    if (int'(reg_raddr) == 0)      reg_rdata = bank_lo;
    else if (int'(reg_raddr) == 1) reg_rdata = bank_hi;
    else                           reg_rdata = lane_rdata;
  end

  AST_SINGLE_LANE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_oh)); // R8
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(run_lane) || $past(done)); // R8

endmodule

// File: tb/bank_dma_bench.sv
module bank_dma_bench;

  localparam int HALF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_waddr = '0, reg_wdata = '0, reg_raddr = '0;
  logic [7:0] reg_rdata;
  logic core_req, core_we, per_req, per_we;
  logic [7:0] core_addr, core_wdata, core_rdata, per_addr, per_wdata, per_rdata;
  logic core_gnt, per_gnt;
  logic gnt_on = 1'b1, stall = 1'b0;
  logic [7:0] cmem [256];
  logic [7:0] pmem [256];
  int pfirst [256];
  int checks = 0, errors = 0, cyc = 0, req_cnt = 0, beat_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bank_dma #(.NUM_LANES(8), .REG_AW(8), .CORE_AW(8), .BANK_W(4), .HALF_W(4)) u_bank_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_gnt(core_gnt),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_gnt(per_gnt)
  );

  assign core_gnt   = gnt_on && (!stall || (cyc % 3) != 2);
  assign per_gnt    = gnt_on && (!stall || (cyc % 2) == 0);
  assign core_rdata = cmem[core_addr];
  assign per_rdata  = pmem[per_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (core_req) req_cnt <= req_cnt + 1;
    if (core_req && core_gnt && per_gnt) begin
      beat_cnt <= beat_cnt + 1;
      if (core_we) cmem[core_addr] <= core_wdata;
      if (per_we) begin
        pmem[per_addr] <= per_wdata;
        if (pfirst[per_addr] < 0) pfirst[per_addr] <= beat_cnt;
      end
    end
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = 8'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output int d);
    @(negedge clk);
    reg_raddr = 8'(a);
    #1 d = int'(reg_rdata);
  endtask

  function automatic int lane_off(input int n, input int k);
    return 32 + 11 * (n - 1) + k;
  endfunction

  task automatic set_lane(input int n, input int ca, input int pa, input int len,
                          input int fb, input int lb);
    for (int b = 0; b < 3; b++) begin
      wr_reg(lane_off(n, b),     (ca  >> (8 * b)) & 255);
      wr_reg(lane_off(n, 3 + b), (pa  >> (8 * b)) & 255);
      wr_reg(lane_off(n, 6 + b), (len >> (8 * b)) & 255);
    end
    wr_reg(lane_off(n, 9), fb);
    wr_reg(lane_off(n, 10), lb);
  endtask

  task automatic wait_lane(input int n, input string req);
    int v = 1;
    for (int t = 0; t < 2000 && v != 0; t++) rd_reg(15 + n, v);
    check(v == 0, req, v, 0);
  endtask

  function automatic int phys_of(input int pa, input int i, input int fb, input int lb);
    int off = (pa % HALF) + i;
    int b = fb;
    for (int s = 0; s < off / HALF; s++) begin
      if (b < lb) b++;
      else if (b > lb) b--;
    end
    return b * HALF + (off % HALF);
  endfunction

  task automatic t_reset();
    int v;
    rd_reg(0, v); check(v == 0, "R1 reset lower bank", v, 0);
    rd_reg(1, v); check(v == 0, "R1 reset upper bank", v, 0);
    rd_reg(16, v); check(v == 0, "R4 reset control", v, 0);
    check(core_req == 0 && per_req == 0, "R5 idle no request", int'(core_req), 0);
  endtask

  task automatic t_regs();
    int v;
    wr_reg(0, 8'h05); wr_reg(1, 8'h0A);
    rd_reg(0, v); check(v == 5, "R1 lower bank readback", v, 5);
    rd_reg(1, v); check(v == 10, "R1 upper bank readback", v, 10);
    set_lane(3, 24'h123456, 24'hABCDEF, 24'h010203, 8'h44, 8'h55);
    rd_reg(lane_off(3, 0), v); check(v == 8'h56, "R2 core addr lsb", v, 8'h56);
    rd_reg(lane_off(3, 2), v); check(v == 8'h12, "R2 core addr msb", v, 8'h12);
    rd_reg(lane_off(3, 4), v); check(v == 8'hCD, "R2 per addr mid", v, 8'hCD);
    rd_reg(lane_off(3, 6), v); check(v == 8'h03, "R2 length lsb", v, 3);
    rd_reg(lane_off(3, 10), v); check(v == 8'h55, "R2 last bank", v, 8'h55);
    wr_reg(24, 8'h01); wr_reg(31, 8'h77);
    rd_reg(24, v); check(v == 0, "R11 reserved 24", v, 0);
    rd_reg(31, v); check(v == 0, "R11 reserved 31", v, 0);
    check(core_req == 0, "R11 reserved write starts nothing", int'(core_req), 0);
  endtask

  task automatic t_to_per();
    int v, ph;
    for (int i = 0; i < 256; i++) cmem[i] = 8'(i * 7 + 3);
    wr_reg(0, 2); wr_reg(1, 7);
    set_lane(1, 8'h10, 8'h03, 8, 3, 3);
    req_cnt = 0;
    wr_reg(16, 8'h01);
    rd_reg(16, v); check(v == 1, "R4 busy reads command", v, 1);
    wait_lane(1, "R4 done reads zero");
    for (int i = 0; i < 8; i++) begin
      ph = phys_of(3, i, 3, 3);
      check(pmem[ph] == cmem[8'h10 + i], "R3 core to peripheral data", int'(pmem[ph]), int'(cmem[8'h10 + i]));
    end
    check(req_cnt == 8, "R9 one byte per granted cycle", req_cnt, 8);
    rd_reg(0, v); check(v == 2, "R7 lower bank restored", v, 2);
    rd_reg(1, v); check(v == 7, "R7 upper bank restored", v, 7);
  endtask

  task automatic t_to_core_up();
    int v, ph;
    for (int i = 0; i < 256; i++) pmem[i] = 8'(i ^ 8'h5A);
    set_lane(2, 8'h80, 8'h0C, 40, 1, 3);
    stall = 1'b1; req_cnt = 0; beat_cnt = 0;
    wr_reg(17, 8'h02);
    wait_lane(2, "R4 done after stalled copy");
    stall = 1'b0;
    for (int i = 0; i < 40; i++) begin
      ph = phys_of(8'h0C, i, 1, 3);
      check(cmem[8'h80 + i] == pmem[ph], "R6 upward bank step and stop", int'(cmem[8'h80 + i]), int'(pmem[ph]));
    end
    check(beat_cnt == 40, "R9 byte count under stalls", beat_cnt, 40);
    check(req_cnt > 40, "R9 stalls hold requests", req_cnt, 41);
    rd_reg(0, v); check(v == 2, "R7 restore after crossings", v, 2);
    rd_reg(1, v); check(v == 7, "R7 restore upper after crossings", v, 7);
  endtask

  task automatic t_to_per_down();
    int v, ph;
    for (int i = 0; i < 256; i++) pmem[i] = 8'h00;
    wr_reg(0, 4); wr_reg(1, 5);
    set_lane(8, 8'h40, 8'h1E, 18, 9, 8);
    wr_reg(23, 8'h01);
    wait_lane(8, "R2 last lane completes");
    for (int i = 0; i < 18; i++) begin
      ph = phys_of(8'h1E, i, 9, 8);
      check(pmem[ph] == cmem[8'h40 + i], "R6 downward bank step", int'(pmem[ph]), int'(cmem[8'h40 + i]));
    end
    rd_reg(0, v); check(v == 4, "R7 lower restored after down", v, 4);
    rd_reg(1, v); check(v == 5, "R7 upper restored after down", v, 5);
  endtask

  task automatic t_zero_and_bad();
    int v;
    set_lane(4, 0, 0, 0, 1, 1);
    req_cnt = 0;
    wr_reg(19, 8'h01);
    repeat (6) @(negedge clk);
    rd_reg(19, v); check(v == 0, "R5 zero length completes", v, 0);
    check(req_cnt == 0, "R5 zero length no access", req_cnt, 0);
    set_lane(5, 0, 0, 4, 1, 1);
    wr_reg(20, 8'h07);
    rd_reg(20, v); check(v == 0, "R4 bad command ignored", v, 0);
    repeat (4) @(negedge clk);
    check(req_cnt == 0, "R4 bad command no access", req_cnt, 0);
  endtask

  task automatic t_order_lock();
    int v, lo0, hi0, win;
    for (int i = 0; i < 256; i++) pfirst[i] = -1;
    for (int i = 8'hC0; i < 8'hF0; i++) pmem[i] = 8'hEE;
    rd_reg(0, lo0); rd_reg(1, hi0);
    set_lane(2, 8'h00, 8'h00, 4, 12, 12);
    set_lane(4, 8'h04, 8'h00, 4, 13, 13);
    set_lane(6, 8'h08, 8'h00, 4, 14, 14);
    set_lane(2, 8'h00, 8'h00, 4, 12, 12);
    gnt_on = 1'b0;
    wr_reg(21, 8'h01);
    repeat (3) @(negedge clk);
    wr_reg(19, 8'h01);
    wr_reg(17, 8'h01);
    wr_reg(21, 8'h02);
    rd_reg(21, v); check(v == 1, "R4 command while busy ignored", v, 1);
    rd_reg(0, win); check(win == 14, "R6 window holds first bank", win, 14);
    wr_reg(0, 3);
    rd_reg(0, v); check(v == win, "R10 bank write ignored while running", v, win);
    wr_reg(lane_off(6, 6), 9);
    rd_reg(lane_off(6, 6), v); check(v == 4, "R10 length write ignored while running", v, 4);
    gnt_on = 1'b1;
    wait_lane(6, "R8 lane 6 done");
    wait_lane(2, "R8 lane 2 done");
    wait_lane(4, "R8 lane 4 done");
    check(pmem[8'hE4] == 8'hEE, "R10 locked length kept", int'(pmem[8'hE4]), 8'hEE);
    check(pmem[8'hE3] == cmem[8'h0B], "R3 lane 6 data", int'(pmem[8'hE3]), int'(cmem[8'h0B]));
    check(pfirst[8'hE0] >= 0 && pfirst[8'hE0] < pfirst[8'hC0], "R8 running lane first", pfirst[8'hE0], pfirst[8'hC0]);
    check(pfirst[8'hC0] < pfirst[8'hD0], "R8 lower lane before higher", pfirst[8'hC0], pfirst[8'hD0]);
    rd_reg(0, v); check(v == lo0, "R7 restore after chain", v, lo0);
    rd_reg(1, v); check(v == hi0, "R7 upper restore after chain", v, hi0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      cmem[i] = '0; pmem[i] = '0; pfirst[i] = -1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_to_per();
    t_to_core_up();
    t_to_per_down();
    t_zero_and_bad();
    t_order_lock();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule